// File: doc/BRIEF.md
# Bidirectional Handshake Bus Port

This block is one 8-bit peripheral port whose data pins form a single shared bus. Data moves in both directions over that bus. A host inside the chip writes bytes into an output latch and reads bytes from an input latch. An external device moves data with two active-low handshake lines. Pulling the strobe low loads the bus value into the input latch. Holding the acknowledge low turns on the port's bus drivers so that the device can take the pending output byte. While acknowledge is high, the port does not drive the bus.

The handshake state is shown on a control/status byte. It holds output-buffer-full (active low), input-buffer-full, the two interrupt-enable bits, the merged interrupt request and three general-purpose output bits. The host changes one control bit at a time with a bit-set/reset command. The output-side enable sits at bit 6 and the input-side enable at bit 4. Bits 0 to 2 are the general-purpose outputs. A single interrupt request combines two conditions, each gated by its own enable: the output latch has been emptied, or the input latch holds a byte. The strobe and acknowledge inputs are asynchronous and pass through a synchronizer of configurable depth.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, obf_n is 1, ibf is 0, intr is 0, gp_out is 0, both interrupt enables are 0 and the output latch is 0.
- R2: bus_oe is 1 exactly while ack_n is 0, with no clock delay. While it is 1, bus_out carries the byte most recently written by the host.
- R3: A host write (host_wr=1 for one cycle) loads host_wdata into the output latch and drives obf_n to 0 on the next clock edge. A rising edge of ack_n returns obf_n to 1 within SYNC_STAGES+2 clock cycles. A write on the same cycle as that edge takes priority.
- R4: A falling edge of stb_n captures bus_in into the input latch and sets ibf to 1 within SYNC_STAGES+2 cycles. Changes on bus_in after stb_n returns high leave the latch unchanged.
- R5: A host read with host_sel=0 puts the input latch on host_rdata one cycle later and clears ibf on that edge, unless a new strobe edge lands on the same cycle.
- R6: A bit-set/reset command (bsr_wr=1) writes bsr_val into control bit bsr_idx. Index 6 is the output-side interrupt enable, index 4 is the input-side interrupt enable, and indices 0 to 2 drive gp_out[0..2]. Indices 3, 5 and 7 are status positions and the command has no effect on them.
- R7: intr is 1 when the output-side enable is 1, obf_n is 1 and the synchronized ack_n is high.
- R8: intr is 1 when the input-side enable is 1, ibf is 1 and the synchronized stb_n is high. intr is 0 when neither the R7 condition nor this condition holds. intr is a registered output.
- R9: A host read with host_sel=1 returns the status byte on host_rdata one cycle later: bit7 obf_n, bit6 output enable, bit5 ibf, bit4 input enable, bit3 intr, bits 2..0 gp_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the output latch |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | Read select: 0 input latch, 1 status byte |
| host_rdata | output | DATA_W | Registered host read data |
| bsr_wr | input | 1 | Bit-set/reset command strobe |
| bsr_idx | input | 3 | Control bit index |
| bsr_val | input | 1 | Value written to the indexed bit |
| bus_in | input | DATA_W | Value sampled from the shared bus |
| bus_out | output | DATA_W | Output latch driven toward the bus |
| bus_oe | output | 1 | Tri-state enable for bus_out |
| stb_n | input | 1 | Active-low strobe from the device |
| ack_n | input | 1 | Active-low acknowledge from the device |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Merged interrupt request |
| gp_out | output | 3 | General-purpose control bits 2..0 |

## Verification
Assertions check the following on every cycle. Every host write leaves obf_n low with the written byte in the latch. obf_n and ibf change only after the matching synchronized handshake edge. A read clears ibf. A bit-set/reset command lands in the output enable. intr is never raised unless an enable was set. The bench's scenarios show the end-to-end behaviour that depends on the external device's timing: the bus drive window, how long handshake edges take to cross the synchronizer, and that the input latch holds its byte once the strobe ends. They also sweep all four enable combinations through every buffer state to check the merged interrupt, and show that commands to the status positions are ignored.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
  localparam int CTL_W      = 8;
  localparam int GP_W       = 3;
  localparam int BIT_OBF    = 7;
  localparam int BIT_IE_OUT = 6;
  localparam int BIT_IBF    = 5;
  localparam int BIT_IE_IN  = 4;
  localparam int BIT_INTR   = 3;
  typedef enum logic {SEL_DATA = 1'b0, SEL_CTRL = 1'b1} rd_sel_e;
endpackage

// File: rtl/bhp_sync.sv
module bhp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[i] <= RST_VAL;
          else     st[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[i] <= RST_VAL;
          else     st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/bhp_out_side.sv
module bhp_out_side #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              ack_s,
  output logic              obf_n,
  output logic [DATA_W-1:0] out_q
);
  logic ack_prev;
  logic ack_rise;

  assign ack_rise = ack_s & ~ack_prev;

  always_ff @(posedge clk) begin
    if (rst) ack_prev <= 1'b1;
    else     ack_prev <= ack_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obf_n <= 1'b1;
      out_q <= '0;
    end else if (host_wr) begin
      out_q <= host_wdata;
      obf_n <= 1'b0;
    end else if (ack_rise) begin
      obf_n <= 1'b1;
    end
  end

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> (!obf_n && out_q == $past(host_wdata)));

  assert_obf_release_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(obf_n) |-> $past(ack_rise));
endmodule

// File: rtl/bhp_in_side.sv
module bhp_in_side #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_s,
  input  logic [DATA_W-1:0] bus_d,
  input  logic              rd_take,
  output logic              ibf,
  output logic [DATA_W-1:0] in_q
);
  logic stb_prev;
  logic stb_fall;

  assign stb_fall = ~stb_s & stb_prev;

  always_ff @(posedge clk) begin
    if (rst) stb_prev <= 1'b1;
    else     stb_prev <= stb_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf  <= 1'b0;
      in_q <= '0;
    end else if (stb_fall) begin
      in_q <= bus_d;
      ibf  <= 1'b1;
    end else if (rd_take) begin
      ibf <= 1'b0;
    end
  end

  assert_ibf_from_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(stb_fall));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_take && !stb_fall) |=> !ibf);

  assert_latch_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(stb_fall) |-> $stable(in_q));
endmodule

// File: rtl/bhp_ctrl.sv
module bhp_ctrl
  import bhp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            bsr_wr,
  input  logic [2:0]      bsr_idx,
  input  logic            bsr_val,
  input  logic            stb_s,
  input  logic            ack_s,
  input  logic            obf_n,
  input  logic            ibf,
  output logic            ie_out,
  output logic            ie_in,
  output logic [GP_W-1:0] gp,
  output logic            intr
);
  logic out_req;
  logic in_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_out <= 1'b0;
      ie_in  <= 1'b0;
    end else if (bsr_wr) begin
      if (bsr_idx == 3'(BIT_IE_OUT)) ie_out <= bsr_val;
      if (bsr_idx == 3'(BIT_IE_IN))  ie_in  <= bsr_val;
    end
  end

  generate
    for (genvar g = 0; g < GP_W; g++) begin : g_gp
      always_ff @(posedge clk) begin
        if (rst) gp[g] <= 1'b0;
        else if (bsr_wr && bsr_idx == 3'(g)) gp[g] <= bsr_val;
      end
    end
  endgenerate

  assign out_req = ack_s & obf_n & ie_out;
  assign in_req  = stb_s & ibf & ie_in;

  always_ff @(posedge clk) begin
    if (rst) intr <= 1'b0;
    else     intr <= out_req | in_req;
  end

  assert_enable_write_R6: assert property (@(posedge clk) disable iff (rst)
    (bsr_wr && bsr_idx == 3'(BIT_IE_OUT)) |=> (ie_out == $past(bsr_val)));

  assert_intr_gated_R8: assert property (@(posedge clk) disable iff (rst)
    intr |-> $past(ie_out || ie_in));
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
  import bhp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_sel,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              bsr_wr,
  input  logic [2:0]        bsr_idx,
  input  logic              bsr_val,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic              stb_n,
  input  logic              ack_n,
  output logic              ibf,
  output logic              obf_n,
  output logic              intr,
  output logic [GP_W-1:0]   gp_out
);
  // Status byte layout needs DATA_W >= CTL_W.
  logic              stb_s, ack_s;
  logic [DATA_W-1:0] bus_d;
  logic [DATA_W-1:0] in_q;
  logic              ie_out, ie_in;
  logic              rd_take;
  logic [DATA_W-1:0] status;

  bhp_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk(clk), .rst(rst), .d(stb_n), .q(stb_s));
  bhp_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_n), .q(ack_s));
  bhp_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_dly (
    .clk(clk), .rst(rst), .d(bus_in), .q(bus_d));

  assign rd_take = host_rd && (rd_sel_e'(host_sel) == SEL_DATA);

  bhp_out_side #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .ack_s(ack_s), .obf_n(obf_n), .out_q(bus_out));

  bhp_in_side #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .stb_s(stb_s), .bus_d(bus_d), .rd_take(rd_take),
    .ibf(ibf), .in_q(in_q));

  bhp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bsr_wr(bsr_wr), .bsr_idx(bsr_idx), .bsr_val(bsr_val),
    .stb_s(stb_s), .ack_s(ack_s), .obf_n(obf_n), .ibf(ibf),
    .ie_out(ie_out), .ie_in(ie_in), .gp(gp_out), .intr(intr));

  // The drivers follow the pin directly so the bus is released at once.
  assign bus_oe = ~ack_n;

  always_comb begin
    status = '0;
    status[BIT_OBF]    = obf_n;
    status[BIT_IE_OUT] = ie_out;
    status[BIT_IBF]    = ibf;
    status[BIT_IE_IN]  = ie_in;
    status[BIT_INTR]   = intr;
    status[GP_W-1:0]   = gp_out;
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= (rd_sel_e'(host_sel) == SEL_CTRL) ? status : in_q;
  end

  assert_read_data_R5: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> (host_rdata == $past(in_q)));
endmodule

// File: tb/tb_bidir_hs_port.sv
module tb_bidir_hs_port;
  localparam int DATA_W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, host_rd = 0, host_sel = 0, bsr_wr = 0, bsr_val = 0;
  logic [2:0] bsr_idx = '0;
  logic [DATA_W-1:0] host_wdata = '0, bus_in = '0;
  logic stb_n = 1, ack_n = 1;
  logic [DATA_W-1:0] host_rdata, bus_out;
  logic bus_oe, ibf, obf_n, intr;
  logic [2:0] gp_out;
  int checks = 0, errors = 0;
  bit done = 0;
  logic e_out = 0, e_in = 0;

  always #4 clk = ~clk;

  bidir_hs_port #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_sel(host_sel), .host_rdata(host_rdata),
    .bsr_wr(bsr_wr), .bsr_idx(bsr_idx), .bsr_val(bsr_val), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .stb_n(stb_n), .ack_n(ack_n),
    .ibf(ibf), .obf_n(obf_n), .intr(intr), .gp_out(gp_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bsr(input int idx, input logic v);
    @(negedge clk); bsr_wr = 1; bsr_idx = 3'(idx); bsr_val = v;
    @(negedge clk); bsr_wr = 0;
  endtask

  task automatic hwrite(input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input logic s);
    @(negedge clk); host_rd = 1; host_sel = s;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic ack_cycle();
    @(negedge clk); ack_n = 0; cyc(4);
    ack_n = 1; cyc(5);
  endtask

  task automatic strobe(input logic [7:0] d);
    @(negedge clk); bus_in = d; stb_n = 0; cyc(4);
    stb_n = 1; cyc(1); bus_in = ~d; cyc(4);
  endtask

  function automatic logic [7:0] stat(input logic gp_unused);
    return {obf_n, e_out, ibf, e_in, intr, gp_out} & {7'h7f, ~gp_unused};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    chk("R1 obf_n", obf_n, 1); chk("R1 ibf", ibf, 0); chk("R1 intr", intr, 0);
    chk("R1 bus_oe", bus_oe, 0); chk("R1 gp", gp_out, 0); chk("R1 bus_out", bus_out, 0);
    hread(1);
    chk("R1 R9 status", host_rdata, 8'h80);

    // R6 general-purpose sweep
    for (int v = 0; v < 8; v++) begin
      for (int b = 0; b < 3; b++) bsr(b, v[b]);
      chk("R6 gp", gp_out, 32'(v));
      hread(1);
      chk("R9 status gp", host_rdata, 32'(8'h80 | v));
    end
    // R6 status positions ignored
    bsr(3, 1); bsr(5, 1); bsr(7, 0); cyc(1);
    hread(1);
    chk("R6 ignored idx", host_rdata, 8'h87);
    chk("R6 ignored ibf", ibf, 0); chk("R6 ignored obf", obf_n, 1);
    for (int b = 0; b < 3; b++) bsr(b, 0);

    // R2 R3 output path sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'(i * 37 + 3);
      hwrite(d);
      chk("R3 obf low", obf_n, 0); chk("R3 latch", bus_out, 32'(d));
      chk("R2 idle oe", bus_oe, 0);
      @(negedge clk); ack_n = 0; #1;
      chk("R2 oe on ack", bus_oe, 1); chk("R2 bus_out", bus_out, 32'(d));
      cyc(4); chk("R3 obf holds during ack", obf_n, 0);
      ack_n = 1; #1;
      chk("R2 oe release", bus_oe, 0);
      cyc(4);
      chk("R3 obf released", obf_n, 1);
    end

    // R4 R5 input path sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      d = 8'(i * 53 + 17);
      strobe(d);
      chk("R4 ibf set", ibf, 1);
      hread(0);
      chk("R4 R5 read data", host_rdata, 32'(d));
      chk("R5 ibf cleared", ibf, 0);
    end

    // R7 R8 interrupt sweep over enable combinations
    for (int c = 0; c < 4; c++) begin
      e_out = c[0]; e_in = c[1];
      bsr(6, e_out); bsr(4, e_in); cyc(3);
      chk("R7 empty out", intr, 32'(e_out));
      hwrite(8'h3c); cyc(3);
      chk("R7 pending out", intr, 0);
      strobe(8'hc3); cyc(1);
      chk("R8 input full", intr, 32'(e_in));
      hread(1);
      chk("R9 status", host_rdata, 32'({1'b0, e_out, 1'b1, e_in, e_in, 3'b000}));
      ack_cycle();
      chk("R7 R8 both", intr, 32'(e_out | e_in));
      hread(0); cyc(3);
      chk("R8 after read", intr, 32'(e_out));
    end
    // R8 intr drops while strobe low
    bsr(6, 0); bsr(4, 1);
    @(negedge clk); bus_in = 8'h11; stb_n = 0; cyc(5);
    chk("R8 low during strobe", intr, 0);
    stb_n = 1; cyc(4);
    chk("R8 high after strobe", intr, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule